// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Bank with Debounce

This block turns a bank of up to 32 input pins into one interrupt line. Each pin passes through a two-flop synchronizer and then an optional debounce filter whose settle time is a power of two of a millisecond tick supplied from outside. An edge detector on the filtered level checks against a per-pin trigger selection (rising, falling, both or off). Each matching edge sets a sticky status bit. Software clears a status bit by writing a one to it.

Masking uses two write-only-ones views of one mask vector. One address sets mask bits and another clears them. The bank's interrupt output is high whenever a status bit is set and its mask bit is clear. Per-pin configuration words come from the neighbouring pin register file as a flat vector of 9-bit words. Status and mask are reached over a plain single-cycle register bus with one write strobe and one read strobe. There is no streaming data at this block's edge, so no valid/ready handshake is used. Every control and status pin is a plain level.

Top module: `eirq_bank`

## Requirements
- R1: The trigger field at bits 4:3 of a pin's configuration word selects which filtered edges set that pin's status bit: 1 selects rising, 2 selects falling, 3 selects both, and 0 selects none. Levels never set status.
- R2: The status register is at byte address 0x080 + 4*BANK and reads back with pin n at bit n. Writing a 1 to a bit clears it, and bits written 0 are unchanged.
- R3: When an edge arrives in the same cycle as a write that clears that pin's status bit, the bit ends up set.
- R4: Writing ones to 0x0A0 + 4*BANK sets those mask bits, and writing ones to 0x0C0 + 4*BANK clears them. Bits written 0 are unchanged. A read of either address returns the mask vector.
- R5: `irq` is high exactly while some pin has its status bit at 1 and its mask bit at 0. Masking does not alter the status bits.
- R6: After reset every mask bit reads 1, every status bit reads 0 and `irq` is low.
- R7: When bit 8 of a pin's configuration word is 1, the pin's filtered level takes a new value only after the synchronized input has differed from it across 2^E `ms_tick` pulses, where E is bits 7:5. Returning to the old level before then restarts the count.
- R8: With debounce off, a change on `pin_in` sets status on the fourth rising clock edge after it is applied: two synchronizer stages, the filter register, then the status register.
- R9: Writes to the status or mask addresses of any other bank have no effect. Reads of unmapped addresses return 0, and data bits above NPIN read 0.
- R10: `bus_rdata` carries the addressed register in the cycle after `bus_rd` is sampled high, and is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond for debounce timing |
| pin_in | input | NPIN | Asynchronous pin levels |
| pin_cfg | input | NPIN*9 | Per-pin configuration words, pin n at bits 9n+8:9n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| irq | output | 1 | Bank interrupt |

## Verification
The bench builds the block with NPIN=8 and BANK=2. With a bank index other than zero, the bench can show that the address decode adds the bank offset and ignores bank 0's status address. With fewer pins than data bits, it can check that the upper read bits stay zero. The table walks every trigger code against both edge directions on separate pins. Directed cases then pin down the four-cycle latency, the set-over-clear collision and a debounce count that is restarted by a bounce.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  // configuration word layout (fields are decoded by neighbouring logic)
  localparam int CFG_W      = 9;
  localparam int TRIG_LSB   = 3;
  localparam int EXP_LSB    = 5;
  localparam int EXP_W      = 3;
  localparam int DEB_EN_BIT = 8;

  // per-bank register bases, bank stride is 4 bytes
  localparam int STAT_BASE = 'h080;
  localparam int MSET_BASE = 'h0A0;
  localparam int MCLR_BASE = 'h0C0;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  function automatic logic trig_hit(trig_e t, logic rise, logic fall);
    case (t)
      TRIG_RISE: return rise;
      TRIG_FALL: return fall;
      TRIG_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eirq_deb.sv
module eirq_deb
  import eirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             din,
  input  logic             en,
  input  logic [EXP_W-1:0] expo,
  output logic             level
);
  localparam int MAXE  = (1 << EXP_W) - 1;
  localparam int CNT_W = (MAXE > 0) ? MAXE : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // last tick index of the settle window: 2^expo - 1
  always_comb lim = CNT_W'((32'd1 << expo) - 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (!en) begin
      level <= din;
      cnt   <= '0;
    end else if (din == level) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == lim) begin
        level <= din;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int BANK = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NPIN-1:0] hit,
  output logic [DW-1:0]   rdata,
  output logic [NPIN-1:0] status,
  output logic [NPIN-1:0] mask
);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_BASE + 4 * BANK);
  localparam logic [AW-1:0] A_MSET = AW'(MSET_BASE + 4 * BANK);
  localparam logic [AW-1:0] A_MCLR = AW'(MCLR_BASE + 4 * BANK);

  logic [NPIN-1:0] wsel;
  logic [NPIN-1:0] st_clr, mk_set, mk_clr;
  logic [DW-1:0]   st_ext, mk_ext, rd_mux;
  logic            unused_w;

  assign wsel     = wdata[NPIN-1:0];
  assign unused_w = ^wdata;
  assign st_clr   = (wr && addr == A_STAT) ? wsel : '0;
  assign mk_set   = (wr && addr == A_MSET) ? wsel : '0;
  assign mk_clr   = (wr && addr == A_MCLR) ? wsel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      // a new edge wins over a clear in the same cycle
      status <= (status & ~st_clr) | hit;
      mask   <= (mask | mk_set) & ~mk_clr;
    end
  end

  always_comb begin
    st_ext = '0;
    st_ext[NPIN-1:0] = status;
    mk_ext = '0;
    mk_ext[NPIN-1:0] = mask;
    if (addr == A_STAT)                       rd_mux = st_ext;
    else if (addr == A_MSET || addr == A_MCLR) rd_mux = mk_ext;
    else                                      rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
    else         rdata <= '0;
  end
endmodule

// File: rtl/eirq_bank.sv
module eirq_bank
  import eirq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int BANK = 0,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ms_tick,
  input  logic [NPIN-1:0]       pin_in,
  input  logic [NPIN*CFG_W-1:0] pin_cfg,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  irq
);
  logic [NPIN-1:0] sync_vec;
  logic [NPIN-1:0] filt_vec;
  logic [NPIN-1:0] prev_vec;
  logic [NPIN-1:0] hit_vec;
  logic [NPIN-1:0] st_vec;
  logic [NPIN-1:0] mk_vec;

  eirq_sync #(.W(NPIN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (sync_vec)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic unused_lo;
    assign unused_lo = ^pin_cfg[p*CFG_W +: TRIG_LSB];

    eirq_deb u_deb (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (ms_tick),
      .din  (sync_vec[p]),
      .en   (pin_cfg[p*CFG_W + DEB_EN_BIT]),
      .expo (pin_cfg[p*CFG_W + EXP_LSB +: EXP_W]),
      .level(filt_vec[p])
    );

    assign hit_vec[p] = trig_hit(trig_e'(pin_cfg[p*CFG_W + TRIG_LSB +: 2]),
                                 filt_vec[p] & ~prev_vec[p],
                                 ~filt_vec[p] & prev_vec[p]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_vec <= '0;
    else        prev_vec <= filt_vec;
  end

  eirq_regs #(.NPIN(NPIN), .AW(AW), .DW(DW), .BANK(BANK)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .hit   (hit_vec),
    .rdata (bus_rdata),
    .status(st_vec),
    .mask  (mk_vec)
  );

  assign irq = |(st_vec & ~mk_vec);
endmodule

// File: rtl/eirq_bank_chk.sv
module eirq_bank_chk
  import eirq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int BANK = 0,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr,
  input logic            rd,
  input logic [AW-1:0]   addr,
  input logic [NPIN-1:0] wsel,
  input logic [DW-1:0]   rdata,
  input logic            irq,
  input logic [NPIN-1:0] st,
  input logic [NPIN-1:0] mk,
  input logic [NPIN-1:0] filt,
  input logic [NPIN-1:0] prev
);
  logic stat_wr, mask_wr;
  assign stat_wr = wr && (addr == AW'(STAT_BASE + 4 * BANK));
  assign mask_wr = wr && (addr == AW'(MSET_BASE + 4 * BANK) ||
                          addr == AW'(MCLR_BASE + 4 * BANK));

  // R2
  st_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st) & ~st) != '0) |-> ($past(stat_wr) &&
      ((($past(st) & ~st) & ~$past(wsel)) == '0)));

  // R1
  st_rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st & ~$past(st) & ~$past(filt ^ prev)) == '0));

  // R4
  mask_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mk != $past(mk)) |-> $past(mask_wr));

  // R5
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st != '0));

  // R10
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd) |-> (rdata == '0));
endmodule

bind eirq_bank eirq_bank_chk #(.NPIN(NPIN), .BANK(BANK), .AW(AW), .DW(DW)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .wr   (bus_wr),
  .rd   (bus_rd),
  .addr (bus_addr),
  .wsel (bus_wdata[NPIN-1:0]),
  .rdata(bus_rdata),
  .irq  (irq),
  .st   (st_vec),
  .mk   (mk_vec),
  .filt (filt_vec),
  .prev (prev_vec)
);

// File: tb/eirq_bank_tb.sv
module eirq_bank_tb;
  localparam int NPIN = 8;
  localparam int BANK = 2;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int CW   = 9;
  localparam logic [AW-1:0] A_STAT = 12'h088;
  localparam logic [AW-1:0] A_MSET = 12'h0A8;
  localparam logic [AW-1:0] A_MCLR = 12'h0C8;

  // {pin[2:0], trig[1:0], from, to, expected status}
  localparam logic [7:0] VEC [8] = '{
    {3'd0, 2'd1, 1'b0, 1'b1, 1'b1},
    {3'd1, 2'd1, 1'b1, 1'b0, 1'b0},
    {3'd2, 2'd2, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'd2, 1'b0, 1'b1, 1'b0},
    {3'd4, 2'd3, 1'b0, 1'b1, 1'b1},
    {3'd5, 2'd3, 1'b1, 1'b0, 1'b1},
    {3'd6, 2'd0, 1'b0, 1'b1, 1'b0},
    {3'd7, 2'd0, 1'b1, 1'b0, 1'b0}
  };

  logic                 clk = 0;
  logic                 rst_n = 0;
  logic                 ms_tick = 0;
  logic [NPIN-1:0]      pin_in = '0;
  logic [NPIN*CW-1:0]   pin_cfg = '0;
  logic                 bus_wr = 0;
  logic                 bus_rd = 0;
  logic [AW-1:0]        bus_addr = '0;
  logic [DW-1:0]        bus_wdata = '0;
  logic [DW-1:0]        bus_rdata;
  logic                 irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] rv;

  always #10 clk = ~clk;

  eirq_bank #(.NPIN(NPIN), .BANK(BANK), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_in(pin_in),
    .pin_cfg(pin_cfg), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [AW-1:0] a, logic [DW-1:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_wr = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bread(logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_rd = 1; bus_addr = a;
    cyc(1);
    d = bus_rdata;
    bus_rd = 0; bus_addr = '0;
  endtask

  task automatic set_cfg(int p, logic [1:0] trig, logic den, logic [2:0] e);
    pin_cfg[p*CW +: CW] = {den, e, trig, 3'b000};
  endtask

  task automatic pulse_tick();
    ms_tick = 1; cyc(1); ms_tick = 0; cyc(2);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);

    // R6: reset state
    check("R6 irq", {31'd0, irq}, 32'd0);
    bread(A_STAT, rv); check("R6 status", rv, 32'h0);
    bread(A_MSET, rv); check("R6 mask", rv, 32'h0000_00FF);

    // R1 / R8: trigger table
    for (int i = 0; i < 8; i++) begin
      int p;
      p = int'(VEC[i][7:5]);
      set_cfg(p, VEC[i][4:3], 1'b0, 3'd0);
      pin_in[p] = VEC[i][2];
      cyc(5);
      bwrite(A_STAT, 32'hFF);
      cyc(1);
      pin_in[p] = VEC[i][1];
      cyc(5);
      bread(A_STAT, rv);
      check($sformatf("R1 vector %0d", i), rv, 32'(VEC[i][0]) << p);
    end

    // R8: exact latency, R5 unmask shows irq
    pin_in[0] = 0; cyc(5);
    bwrite(A_STAT, 32'hFF);
    bwrite(A_MCLR, 32'h01);
    pin_in[0] = 1;
    cyc(3);
    check("R8 before 4th edge", {31'd0, irq}, 32'd0);
    cyc(1);
    check("R8 at 4th edge", {31'd0, irq}, 32'd1);

    // R4 / R5: masking
    bwrite(A_MSET, 32'h01);
    check("R5 masked irq", {31'd0, irq}, 32'd0);
    bread(A_STAT, rv); check("R5 status kept under mask", rv, 32'h01);
    bread(A_MSET, rv); check("R4 mask after set", rv, 32'hFF);
    bwrite(A_MCLR, 32'h00);
    check("R4 zero write no effect", {31'd0, irq}, 32'd0);
    bwrite(A_MCLR, 32'h01);
    check("R5 unmasked irq", {31'd0, irq}, 32'd1);
    bread(A_MCLR, rv); check("R4 mask after clear", rv, 32'hFE);

    // R9: other bank addresses
    bwrite(12'h080, 32'hFF);
    bread(A_STAT, rv); check("R9 other bank clear ignored", rv, 32'h01);
    bwrite(12'h0A0, 32'hFF);
    check("R9 other bank mask ignored", {31'd0, irq}, 32'd1);
    bread(12'h084, rv); check("R9 unmapped read", rv, 32'h0);

    // R2: write-one-to-clear
    bwrite(A_STAT, 32'h00);
    bread(A_STAT, rv); check("R2 zero write no effect", rv, 32'h01);
    bwrite(A_STAT, 32'h01);
    bread(A_STAT, rv); check("R2 clear", rv, 32'h00);
    check("R5 irq low after clear", {31'd0, irq}, 32'd0);

    // R3: edge coinciding with clear
    set_cfg(7, 2'd3, 1'b0, 3'd0);
    pin_in[7] = ~pin_in[7];
    cyc(5);
    bread(A_STAT, rv); check("R3 first edge", rv, 32'h80);
    pin_in[7] = ~pin_in[7];
    cyc(3);
    bwrite(A_STAT, 32'h80);
    bread(A_STAT, rv); check("R3 set wins over clear", rv, 32'h80);
    bwrite(A_STAT, 32'h80);
    bread(A_STAT, rv); check("R3 plain clear", rv, 32'h00);

    // R7: debounce, 2^2 = 4 ticks
    pin_in[6] = 0; cyc(5);
    set_cfg(6, 2'd1, 1'b1, 3'd2);
    bwrite(A_STAT, 32'hFF);
    pin_in[6] = 1; cyc(4);
    repeat (3) pulse_tick();
    cyc(3);
    bread(A_STAT, rv); check("R7 not settled after 3 ticks", rv, 32'h00);
    pin_in[6] = 0; cyc(4);
    pin_in[6] = 1; cyc(4);
    repeat (3) pulse_tick();
    cyc(3);
    bread(A_STAT, rv); check("R7 bounce restarts count", rv, 32'h00);
    pulse_tick();
    cyc(4);
    bread(A_STAT, rv); check("R7 settled after 4 ticks", rv, 32'h40);

    // R10: idle read data
    cyc(1);
    check("R10 idle rdata", bus_rdata, 32'h0);

    report();
  end
endmodule